// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of every line in one core's cache in a snooping multiprocessor that uses write-invalidate. Each line is Modified, Exclusive, Shared or Invalid. The block serves one local read or write request per cycle and one snooped request from another core per cycle. For each, it works out the line's next state. It also produces the bus transaction the local request needs, a writeback strobe for dirty data, and a shared/hit response to the snoop.

The cache is direct-mapped. The low address bits select a line, and the remaining bits form a tag that is stored with the state. A write to an Exclusive line becomes Modified silently, with no bus traffic. A write to a Shared line must first broadcast an invalidate. If a snoop and a local request arrive in the same cycle, the snoop is applied first. The local request then sees the state the snoop left behind. All outputs are registered and appear one cycle after the inputs that caused them.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and all outputs are low, so the first read of any address misses.
- R2: A read miss issues a bus read (`bus_op_o` = 01) at the request address. The line fills as Exclusive when `bus_shared_i` is low in the request cycle, and as Shared when it is high.
- R3: A read that hits a valid line with a matching tag asserts `hit_o` and issues no bus transaction.
- R4: A write that hits an Exclusive line issues no bus transaction and leaves the line Modified.
- R5: A write that hits a Shared line issues an invalidate (`bus_op_o` = 11) and leaves the line Modified. A write that hits a Modified line is silent.
- R6: A write miss issues a read-for-ownership (`bus_op_o` = 10) and installs the line as Modified.
- R7: A snooped read (`snp_op_i` = 01) that matches a valid line asserts `snp_hit_o`. If the line is Modified it also asserts `flush_o`, and the line becomes Shared. Exclusive becomes Shared, and Shared stays Shared.
- R8: A snooped read-for-ownership (10) or invalidate (11) that matches a valid line asserts `snp_hit_o` and makes the line Invalid. It asserts `flush_o` first if the line was Modified.
- R9: A miss that replaces a Modified line with a different tag asserts `wb_o`, with `wb_addr_o` holding the victim's address. A clean victim causes no writeback.
- R10: A snoop with op 00, or one whose tag differs from the stored tag, changes no state and raises no output.
- R11: When a snoop and a local request arrive in the same cycle, the snoop takes effect first and the local request is decided on the state that results.
- R12: Every output reflects the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Local request present |
| req_write_i | input | 1 | Local request is a write |
| req_addr_i | input | ADDR_W | Local line address |
| snp_valid_i | input | 1 | Snooped request present |
| snp_op_i | input | 2 | Snooped op: 00 none, 01 read, 10 read-for-ownership, 11 invalidate |
| snp_addr_i | input | ADDR_W | Snooped line address |
| bus_shared_i | input | 1 | Another core holds the line requested by a local bus read |
| hit_o | output | 1 | Previous local request hit |
| bus_req_o | output | 1 | Bus transaction issued |
| bus_op_o | output | 2 | Bus op: 01 read, 10 read-for-ownership, 11 invalidate |
| bus_addr_o | output | ADDR_W | Bus transaction address |
| wb_o | output | 1 | Dirty victim writeback strobe |
| wb_addr_o | output | ADDR_W | Victim address |
| snp_hit_o | output | 1 | This cache held the snooped line (shared response) |
| flush_o | output | 1 | Modified data supplied in response to a snoop |

## Verification
The bench walks one line through every transition. It watches for four mistakes:
- An Exclusive line that wrongly broadcasts on a write, or a Shared line that upgrades without the invalidate. Either shows up as a bus op where none or 11 was expected.
- A snoop on a Modified line that drops the flush, which would silently lose dirty data.
- An eviction that writes back a clean victim, or reports the new address instead of the victim's.
- The same-cycle snoop-and-write case. A design that orders the two the wrong way would report a silent hit instead of a read-for-ownership.

Long random mixes of requests and snoops then run against the model on every clock.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_RD   = 2'b01,
    OP_RDX  = 2'b10,
    OP_INV  = 2'b11
  } bus_op_e;
endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic                 snp_valid_i,
  input  logic [1:0]           snp_op_i,
  input  logic [IDX_W-1:0]     snp_idx_i,
  input  logic [TAG_W-1:0]     snp_tag_i,
  input  line_st_e             st_i  [LINES],
  input  logic [TAG_W-1:0]     tag_i [LINES],
  output line_st_e             st_o  [LINES],
  output logic                 hit_o,
  output logic                 flush_o
);
  logic [LINES-1:0] match_w;
  logic [LINES-1:0] flush_w;
  logic             snp_act;

  assign snp_act = snp_valid_i && (snp_op_i != OP_NONE);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign match_w[i] = snp_act && (snp_idx_i == IDX_W'(i)) &&
                        (tag_i[i] == snp_tag_i) && (st_i[i] != ST_I);
    assign flush_w[i] = match_w[i] && (st_i[i] == ST_M);
    // read downgrades to shared; ownership requests and invalidates kill the copy
    assign st_o[i]    = !match_w[i] ? st_i[i] :
                        (snp_op_i == OP_RD) ? ST_S : ST_I;
  end

  assign hit_o   = |match_w;
  assign flush_o = |flush_w;
endmodule

// File: rtl/mesi_local_unit.sv
module mesi_local_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  line_st_e         cur_st_i,
  input  logic [TAG_W-1:0] cur_tag_i,
  input  logic             bus_shared_i,
  output logic             upd_o,
  output line_st_e         nxt_st_o,
  output logic             hit_o,
  output bus_op_e          bus_op_o,
  output logic             evict_o
);
  always_comb begin
    upd_o    = 1'b0;
    nxt_st_o = cur_st_i;
    hit_o    = 1'b0;
    bus_op_o = OP_NONE;
    evict_o  = 1'b0;
    if (req_valid_i) begin
      hit_o = (cur_st_i != ST_I) && (cur_tag_i == req_tag_i);
      if (hit_o) begin
        if (req_write_i) begin
          upd_o    = 1'b1;
          nxt_st_o = ST_M;
          if (cur_st_i == ST_S) bus_op_o = OP_INV;
        end
      end else begin
        upd_o    = 1'b1;
        evict_o  = (cur_st_i == ST_M);
        bus_op_o = req_write_i ? OP_RDX : OP_RD;
        nxt_st_o = req_write_i ? ST_M : (bus_shared_i ? ST_S : ST_E);
      end
    end
  end
endmodule

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  line_st_e         snp_st_i [LINES],
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  line_st_e         upd_st_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  output line_st_e         st_q_o  [LINES],
  output logic [TAG_W-1:0] tag_q_o [LINES]
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = upd_i && (upd_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q_o[i]  <= ST_I;
        tag_q_o[i] <= '0;
      end else if (sel) begin
        st_q_o[i]  <= upd_st_i;
        tag_q_o[i] <= upd_tag_i;
      end else begin
        st_q_o[i]  <= snp_st_i[i];
      end
    end

    AST_FILL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q_o[i] != ST_I && $past(st_q_o[i]) == ST_I) |->
        $past(upd_i && upd_idx_i == IDX_W'(i))); // R2
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              bus_shared_i,
  output logic              hit_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              snp_hit_o,
  output logic              flush_o
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  line_st_e         st_q   [LINES];
  line_st_e         st_mid [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag;
  logic             snp_hit_w, flush_w;
  logic             upd_w, hit_w, evict_w;
  line_st_e         nxt_st_w;
  bus_op_e          bus_op_w;

  assign req_idx = req_addr_i[IDX_W-1:0];
  assign req_tag = req_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  mesi_snoop_unit #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_op_i    (snp_op_i),
    .snp_idx_i   (snp_idx),
    .snp_tag_i   (snp_tag),
    .st_i        (st_q),
    .tag_i       (tag_q),
    .st_o        (st_mid),
    .hit_o       (snp_hit_w),
    .flush_o     (flush_w)
  );

  // local request sees the post-snoop state of its line
  mesi_local_unit #(.TAG_W(TAG_W)) u_local (
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_tag_i    (req_tag),
    .cur_st_i     (st_mid[req_idx]),
    .cur_tag_i    (tag_q[req_idx]),
    .bus_shared_i (bus_shared_i),
    .upd_o        (upd_w),
    .nxt_st_o     (nxt_st_w),
    .hit_o        (hit_w),
    .bus_op_o     (bus_op_w),
    .evict_o      (evict_w)
  );

  mesi_state_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snp_st_i  (st_mid),
    .upd_i     (upd_w),
    .upd_idx_i (req_idx),
    .upd_st_i  (nxt_st_w),
    .upd_tag_i (req_tag),
    .st_q_o    (st_q),
    .tag_q_o   (tag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      bus_op_o   <= OP_NONE;
      bus_addr_o <= '0;
      wb_o       <= 1'b0;
      wb_addr_o  <= '0;
      snp_hit_o  <= 1'b0;
      flush_o    <= 1'b0;
    end else begin
      hit_o      <= hit_w;
      bus_op_o   <= bus_op_w;
      bus_addr_o <= req_addr_i;
      wb_o       <= evict_w;
      wb_addr_o  <= {tag_q[req_idx], req_idx};
      snp_hit_o  <= snp_hit_w;
      flush_o    <= flush_w;
    end
  end

  assign bus_req_o = (bus_op_o != OP_NONE);

  AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(snp_valid_i) && $past(snp_op_i) != OP_NONE)); // R7
  AST_WB_WITH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (bus_req_o && bus_op_o != OP_INV && !hit_o)); // R9
  AST_INV_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_op_o == OP_INV) |-> $past(req_valid_i && req_write_i)); // R5
  AST_READ_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !$past(req_write_i)) |-> !bus_req_o); // R3
  AST_RFO_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_op_o == OP_RDX) |-> ($past(req_write_i) && !hit_o)); // R6
endmodule

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;
  localparam int LINES  = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              snp_valid = 1'b0;
  logic [1:0]        snp_op = 2'b00;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              bus_shared = 1'b0;
  logic              hit, bus_req, wb, snp_hit, flush;
  logic [1:0]        bus_op;
  logic [ADDR_W-1:0] bus_addr, wb_addr;

  int checks = 0;
  int failures = 0;

  // reference: 0 I, 1 S, 2 E, 3 M
  int m_st [LINES];
  int m_tg [LINES];

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) u_mesi_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .bus_shared_i(bus_shared),
    .hit_o(hit), .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_addr_o(bus_addr),
    .wb_o(wb), .wb_addr_o(wb_addr), .snp_hit_o(snp_hit), .flush_o(flush)
  );

  task automatic step(input bit rv, input bit wr, input logic [7:0] a,
                      input bit sv, input logic [1:0] op, input logic [7:0] sa,
                      input bit sh, input string rq);
    bit e_hit = 0, e_wb = 0, e_sh = 0, e_fl = 0;
    int e_op = 0;
    logic [7:0] e_wa = '0;
    bit bad;
    req_valid = rv; req_write = wr; req_addr = a;
    snp_valid = sv; snp_op = op; snp_addr = sa; bus_shared = sh;
    if (sv && op != 0) begin
      int i = sa % LINES;
      int t = sa / LINES;
      if (m_st[i] != 0 && m_tg[i] == t) begin
        e_sh = 1;
        if (m_st[i] == 3) e_fl = 1;
        m_st[i] = (op == 1) ? 1 : 0;
      end
    end
    if (rv) begin
      int i = a % LINES;
      int t = a / LINES;
      e_hit = (m_st[i] != 0 && m_tg[i] == t);
      if (e_hit) begin
        if (wr) begin
          if (m_st[i] == 1) e_op = 3;
          m_st[i] = 3;
        end
      end else begin
        if (m_st[i] == 3) begin
          e_wb = 1;
          e_wa = 8'(m_tg[i] * LINES + i);
        end
        e_op = wr ? 2 : 1;
        m_st[i] = wr ? 3 : (sh ? 1 : 2);
        m_tg[i] = t;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    bad = (hit !== e_hit) || (bus_req !== (e_op != 0)) || (int'(bus_op) != e_op) ||
          (e_op != 0 && bus_addr !== a) || (wb !== e_wb) || (e_wb && wb_addr !== e_wa) ||
          (snp_hit !== e_sh) || (flush !== e_fl);
    if (bad) begin
      failures++;
      $display("FAIL %s: got hit=%0b op=%0d addr=%h wb=%0b wa=%h sh=%0b fl=%0b exp hit=%0b op=%0d addr=%h wb=%0b wa=%h sh=%0b fl=%0b",
               rq, hit, bus_op, bus_addr, wb, wb_addr, snp_hit, flush,
               e_hit, e_op, a, e_wb, e_wa, e_sh, e_fl);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tg[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if ({hit, bus_req, wb, snp_hit, flush} !== 5'b0) begin
      failures++;
      $display("FAIL R1: got outputs=%b exp 00000", {hit, bus_req, wb, snp_hit, flush});
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 8'h10, 0, 2'b00, 8'h00, 0, "R1");   // first read misses, fills E
    step(1, 0, 8'h10, 0, 2'b00, 8'h00, 0, "R3");   // quiet read hit
    step(1, 1, 8'h10, 0, 2'b00, 8'h00, 0, "R4");   // E -> M silently
    step(0, 0, 8'h00, 1, 2'b01, 8'h10, 0, "R7");   // snoop read on M: flush, -> S
    step(1, 1, 8'h10, 0, 2'b00, 8'h00, 0, "R5");   // S write: invalidate
    step(1, 1, 8'h10, 0, 2'b00, 8'h00, 0, "R5");   // M write silent
    step(0, 0, 8'h00, 1, 2'b11, 8'h10, 0, "R8");   // invalidate on M: flush
    step(1, 0, 8'h21, 0, 2'b00, 8'h00, 1, "R2");   // shared fill
    step(1, 1, 8'h21, 0, 2'b00, 8'h00, 0, "R5");   // S -> M with INV
    step(0, 0, 8'h00, 1, 2'b01, 8'h21, 0, "R7");   // M -> S with flush
    step(0, 0, 8'h00, 1, 2'b10, 8'h21, 0, "R8");   // S killed by RFO, no flush
    step(1, 0, 8'h21, 0, 2'b00, 8'h00, 0, "R8");   // now misses
    step(0, 0, 8'h00, 1, 2'b01, 8'h21, 1, "R7");   // E -> S, no flush
    step(1, 1, 8'h32, 0, 2'b00, 8'h00, 0, "R6");   // write miss: RFO
    step(1, 0, 8'h42, 0, 2'b00, 8'h00, 0, "R9");   // evict dirty 0x32
    step(1, 0, 8'h52, 0, 2'b00, 8'h00, 0, "R9");   // evict clean: no wb
    step(0, 0, 8'h00, 1, 2'b00, 8'h52, 0, "R10");  // op none
    step(0, 0, 8'h00, 1, 2'b11, 8'h56, 0, "R10");  // tag mismatch
    step(1, 1, 8'h52, 0, 2'b00, 8'h00, 0, "R10");  // still E: silent upgrade
    step(1, 1, 8'h52, 1, 2'b10, 8'h52, 0, "R11");  // snoop kills first: RFO
    step(1, 0, 8'h03, 1, 2'b01, 8'h03, 0, "R11");  // snoop sees I, local fills E
    step(1, 0, 8'h13, 1, 2'b01, 8'h03, 0, "R11");  // snoop E->S, then clean evict
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a = 8'($urandom_range(0, 15));
      logic [7:0] s = 8'($urandom_range(0, 15));
      step(1'($urandom), 1'($urandom), a, 1'($urandom), 2'($urandom), s,
           1'($urandom), "R12");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule